// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over a fixed number of clock cycles and returns a product twice as wide as the operands. A pulse on the start input, taken while the block is idle, captures both operands. The multiplicand goes into a register that holds still for the whole operation. The multiplier goes into the low half of a double-width product register. The block then runs one step per cycle. In each step it tests bit 0 of the product register. When that bit is 1, it adds the multiplicand to the upper half through an adder only as wide as one operand. It then shifts the whole register right by one place, and the carry out of the adder enters at the top.

The busy output is high while the steps run. The done output pulses for a single cycle in the cycle that busy falls, and the product is valid at that point. The product then holds until another operation is accepted. A start request seen while busy is dropped.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and product_o is all zeros.
- R2: A start_i seen high at a rising edge while busy_o is 0 captures mcand_i and mplier_i, and busy_o is 1 from the following cycle on.
- R3: busy_o stays high for exactly WIDTH cycles (32 by default). In the cycle where it falls, done_o is 1 for that single cycle.
- R4: When done_o is 1, product_o equals the full unsigned product mcand_i × mplier_i as captured at start. This includes all-ones × all-ones, where the upper-half addition carries out.
- R5: start_i raised while busy_o is 1 is ignored. The running result and its completion cycle do not change.
- R6: product_o does not change from the done_o cycle until the next accepted start.
- R7: Changes on mcand_i or mplier_i after the start cycle have no effect on the running product.
- R8: A zero in either operand gives a zero product.
- R9: A start_i given in the same cycle as done_o is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | Steps are in progress |
| done_o | output | 1 | One-cycle pulse: product is valid |
| product_o | output | 2*WIDTH | Product register contents |

## Verification
Some properties are checked by assertions on every cycle: the length of each busy run, done being a single-cycle pulse that coincides with busy falling, the multiplicand register holding still while busy, and the product holding while idle with no start. The bench scenarios show the rest. These are the arithmetic result for corner operands (where the carry into the top bit matters), that a start request during a run is dropped, that operand changes mid-run have no effect, and that a back-to-back start in the done cycle is accepted.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sam_state_e;
endpackage

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  assign sum_o = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  sam_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic done_q;
  logic last_step;

  assign load_o    = start_i && (state_q == ST_IDLE);
  assign step_o    = (state_q == ST_RUN);
  assign last_step = step_o && (cnt_q == LAST);
  assign busy_o    = step_o;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (last_step) begin
        state_q <= ST_IDLE;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // independent run-length counter for the R3 check
  logic [CNT_W:0] run_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len_q <= '0;
    else if (busy_o) run_len_q <= run_len_q + 1'b1;
    else             run_len_q <= '0;
  end

  a_r3_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len_q == (CNT_W+1)'(WIDTH)));
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_done_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH:0]   add_res;
  logic [WIDTH:0]   upper_next;

  sam_adder #(.WIDTH(WIDTH)) u_add (
    .a_i  (prod_q[PW-1:WIDTH]),
    .b_i  (mcand_q),
    .sum_o(add_res)
  );

  // carry bit joins the sum so the shift keeps all sum bits
  assign upper_next = prod_q[0] ? add_res : {1'b0, prod_q[PW-1:WIDTH]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= {upper_next, prod_q[WIDTH-1:1]};
    end
  end

  assign prod_o = prod_q;

  a_r7_mcand_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(mcand_q));
  a_r6_prod_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(prod_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, step;

  sam_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  sam_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .prod_o  (product_o)
  );

  a_r5_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done;
  logic [2*W-1:0] prod;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shift_add_mul #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(a), .mplier_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // waits from the first busy negedge until done; returns busy count
  task automatic wait_done(output int n);
    n = 1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (done) break;
      if (busy) n++;
    end
  endtask

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    int n;
    logic [63:0] exp = 64'(x) * 64'(y);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", 64'(busy), 64'd1);
    wait_done(n);
    check(n == W && !busy && done, "R3", 64'(n), 64'(W));
    check(prod == exp, req, prod, exp);
    @(negedge clk);
    check(done == 1'b0, "R3", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    check(!busy && !done && prod == '0, "R1", prod, 64'd0);
  endtask

  task automatic t_corners();
    run_op('1, '1, "R4");
    run_op('1, 32'd1, "R4");
    run_op(32'h8000_0000, 32'd2, "R4");
    run_op(32'd0, 32'hDEAD_BEEF, "R8");
    run_op(32'h1234_5678, 32'd0, "R8");
    run_op(32'd2, 32'd11, "R4");
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++) run_op($urandom, $urandom, "R4");
  endtask

  task automatic t_start_ignored();
    int n;
    logic [63:0] exp = 64'(32'hCAFE_0001) * 64'(32'h0BAD_F00D);
    @(negedge clk);
    a = 32'hCAFE_0001; b = 32'h0BAD_F00D; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    a = 32'hFFFF_FFFF; b = 32'h1357_9BDF; start = 1'b1;  // R5, R7
    @(negedge clk);
    start = 1'b0;
    n = 6;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (done) break;
      if (busy) n++;
    end
    check(n == W, "R5", 64'(n), 64'(W));
    check(prod == exp, "R7", prod, exp);
  endtask

  task automatic t_hold();
    logic [63:0] held = prod;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      a = $urandom; b = $urandom;
    end
    check(prod == held && !busy, "R6", prod, held);
  endtask

  task automatic t_back_to_back();
    int n;
    logic [63:0] exp2 = 64'(32'd77777) * 64'(32'd99991);
    @(negedge clk);
    a = 32'd1000; b = 32'd3000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    check(prod == 64'd3000000, "R4", prod, 64'd3000000);
    a = 32'd77777; b = 32'd99991; start = 1'b1;  // in the done cycle
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", 64'(busy), 64'd1);
    wait_done(n);
    check(n == W && prod == exp2, "R9", prod, exp2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_corners();
    t_random();
    t_start_ignored();
    t_hold();
    t_back_to_back();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule